// File: doc/BRIEF.md
# Sample-and-Interrupt Latch Controller

This block is the glue that sits around an external time comparator in a pulse-timing receiver loop. The block alternates between two phases. In the first, the host loads the comparator's six digits one at a time. In the second, the host waits for a match and reads a sample of the incoming waveform. Both phases raise requests on one shared active-low interrupt line. The host picks the active phase with two level inputs. Each input holds its own latch cleared while it is low.

Six digit-scan strobes are ORed together. A rising edge of the combined strobe sets a digit request latch. A match pulse from the comparator sets a sample request latch. In the same cycle it captures the conditioned navigation input into a data output. Before it is sampled, the raw navigation input is widened by a retriggerable one-shot to a fixed guard width, measured in clocks. All pins are plain control and status signals, and no pin carries a stream, so the block has no valid/ready handshake and no back-pressure.

Top module: `samp_irq_ctrl`

## Requirements
- R1: After reset, `irq_n` is 1 and `samp_data` is 0.
- R2: While `digit_en` is 1, a rising edge of the OR of the six `digit_strobe` bits, seen at a clock edge, sets the digit request. `irq_n` is 0 from the next cycle on. A strobe that stays high sets the request only once. After a clear, re-enabling while the strobe is still high does not set the request again.
- R3: While `digit_en` is 0, the digit request is clear and stays clear. If a strobe edge arrives in the same cycle as `digit_en` = 0, the clear wins.
- R4: While `samp_en` is 1, a `match_pulse` of 1 at a clock edge sets the sample request. In the same edge it loads `samp_data` with the conditioned input as it stood during that cycle.
- R5: While `samp_en` is 0, the sample request and `samp_data` are 0 from the next cycle on. A match in the same cycle as `samp_en` = 0 has no effect.
- R6: `irq_n` is 0 exactly when the digit request or the sample request is set.
- R7: When `nav_in` is seen at 1 at an edge after being seen at 0, the conditioned input is 1 for exactly `STRETCH_CLKS` cycles, starting in the next cycle. This holds no matter how long `nav_in` stays high. A match in any of those cycles captures 1. A match at the edge that detects the rise, or at the edge after the last of those cycles, captures 0.
- R8: A new rising edge of `nav_in` while the conditioned input is 1 restarts the full `STRETCH_CLKS` count.
- R9: `match_mon` follows `match_pulse` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (1 MHz in the target loop) |
| rst_n | input | 1 | Asynchronous active-low reset |
| digit_strobe | input | N_STROBES | Digit-scan strobes from the comparator |
| digit_en | input | 1 | Digit request enable; low clears and holds clear |
| samp_en | input | 1 | Sample request enable; low clears and holds clear |
| match_pulse | input | 1 | One-clock comparator match pulse |
| nav_in | input | 1 | Raw navigation pulse input |
| irq_n | output | 1 | Shared active-low interrupt |
| samp_data | output | 1 | Captured conditioned input |
| match_mon | output | 1 | Match pulse brought out for monitoring |

## Verification
A wrong request latch shows on `irq_n` one cycle after the strobe edge, match or clear that should have moved it. A wrong stretch counter shows only when a match falls near the end of the guard window. For that reason, matches are placed at the cycles just inside and just outside the window, and around a retrigger. A lost edge-detect register shows as a second interrupt from a held strobe, which is visible after the next clear and re-enable.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int unsigned DEF_STRETCH_CLKS = 70;
  localparam int unsigned DEF_N_STROBES    = 6;
endpackage

// File: rtl/sic_stretch.sv
module sic_stretch #(
  parameter int unsigned STRETCH_CLKS = sic_pkg::DEF_STRETCH_CLKS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic widened
);
  localparam int unsigned CW = $clog2(STRETCH_CLKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH_CLKS);

  logic          raw_q;
  logic [CW-1:0] remain;
  logic          rise;

  assign rise    = raw_in & ~raw_q;
  assign widened = (remain != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= 1'b0;
      remain <= '0;
    end else begin
      raw_q <= raw_in;
      if (rise)             remain <= LOAD;
      else if (remain != 0) remain <= remain - 1'b1;
    end
  end

  // R7 R8
  rise_starts_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_in && !raw_q) |=> (widened && remain == LOAD));
  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remain <= LOAD);
endmodule

// File: rtl/sic_digit_latch.sv
module sic_digit_latch #(
  parameter int unsigned N_STROBES = sic_pkg::DEF_N_STROBES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_STROBES-1:0] strobes,
  input  logic                 enable,
  output logic                 req
);
  logic any_q, any_now, edge_seen;

  assign any_now   = |strobes;
  assign edge_seen = any_now & ~any_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_q <= 1'b0;
      req   <= 1'b0;
    end else begin
      any_q <= any_now;
      if (!enable)        req <= 1'b0;
      else if (edge_seen) req <= 1'b1;
    end
  end

  // R3
  digit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !req);
  // R2
  digit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && edge_seen) |=> req);
endmodule

// File: rtl/sic_sample_latch.sv
module sic_sample_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic match,
  input  logic level,
  output logic req,
  output logic data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req  <= 1'b0;
      data <= 1'b0;
    end else if (!enable) begin
      req  <= 1'b0;
      data <= 1'b0;
    end else if (match) begin
      req  <= 1'b1;
      data <= level;
    end
  end

  // R5
  sample_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!req && !data));
  // R4
  sample_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && match) |=> (req && data == $past(level)));
endmodule

// File: rtl/samp_irq_ctrl.sv
module samp_irq_ctrl #(
  parameter int unsigned STRETCH_CLKS = sic_pkg::DEF_STRETCH_CLKS,
  parameter int unsigned N_STROBES    = sic_pkg::DEF_N_STROBES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_STROBES-1:0] digit_strobe,
  input  logic                 digit_en,
  input  logic                 samp_en,
  input  logic                 match_pulse,
  input  logic                 nav_in,
  output logic                 irq_n,
  output logic                 samp_data,
  output logic                 match_mon
);
  logic nav_wide, digit_req, samp_req;

  sic_stretch #(.STRETCH_CLKS(STRETCH_CLKS)) stretch_i (
    .clk(clk), .rst_n(rst_n), .raw_in(nav_in), .widened(nav_wide));

  sic_digit_latch #(.N_STROBES(N_STROBES)) digit_i (
    .clk(clk), .rst_n(rst_n), .strobes(digit_strobe),
    .enable(digit_en), .req(digit_req));

  sic_sample_latch sample_i (
    .clk(clk), .rst_n(rst_n), .enable(samp_en), .match(match_pulse),
    .level(nav_wide), .req(samp_req), .data(samp_data));

  assign irq_n     = ~(digit_req | samp_req);
  assign match_mon = match_pulse;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_n && !samp_data));
endmodule

// File: tb/samp_irq_ctrl_tb.sv
module samp_irq_ctrl_tb_top;
  localparam int CLK_NS = 10;
  localparam int W  = 70;
  localparam int NS = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] strb = '0;
  logic den = 1'b0, sen = 1'b0, mt = 1'b0, nav = 1'b0;
  logic irq_n, sdata, mmon;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  int m_cnt = 0;
  bit m_nav_q = 0, m_any_q = 0, m_dreq = 0, m_sreq = 0, m_data = 0;

  always #(CLK_NS/2) clk = ~clk;

  samp_irq_ctrl #(.STRETCH_CLKS(W), .N_STROBES(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .digit_strobe(strb), .digit_en(den),
    .samp_en(sen), .match_pulse(mt), .nav_in(nav),
    .irq_n(irq_n), .samp_data(sdata), .match_mon(mmon));

  function automatic bit exp_irq(bit d, bit s);
    return !(d || s);
  endfunction

  task automatic model_edge();
    bit wide_now = (m_cnt != 0);
    bit any_now  = |strb;
    if (nav && !m_nav_q) m_cnt = W; else if (m_cnt > 0) m_cnt--;
    if (!den) m_dreq = 0; else if (any_now && !m_any_q) m_dreq = 1;
    if (!sen) begin m_sreq = 0; m_data = 0; end
    else if (mt) begin m_sreq = 1; m_data = wide_now; end
    m_nav_q = nav; m_any_q = any_now;
  endtask

  task automatic chk(string tag, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, irq_n, exp_irq(m_dreq, m_sreq), "irq_n");
    chk(tag, sdata, m_data, "samp_data");
    chk("R9", mmon, mt, "match_mon");
  endtask

  // inputs already set; one clock edge, then compare away from the edge
  task automatic step(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", irq_n, 1'b1, "irq_n");
    chk("R1", sdata, 1'b0, "samp_data");

    // R2 single strobe on bit 3
    den = 1; strb = 6'b001000; step("R2");
    chk("R2", irq_n, 1'b0, "irq_n after strobe");
    idle(3, "R2");                      // held strobe
    den = 0; step("R3");
    chk("R3", irq_n, 1'b1, "irq_n cleared");
    den = 1; idle(3, "R2");             // still high: no new set
    chk("R2", irq_n, 1'b1, "held strobe sets once");
    strb = 0; step("R2");
    // R3 clear wins over simultaneous edge
    den = 0; strb = 6'b000001; step("R3");
    chk("R3", irq_n, 1'b1, "clear beats edge");
    strb = 0; step("R3");

    // R7 window edges
    sen = 1; nav = 1; mt = 1; step("R7");   // match at detecting edge -> 0
    chk("R7", sdata, 1'b0, "match on rise edge");
    chk("R4", irq_n, 1'b0, "sample request");
    step("R7");                              // first stretched cycle
    chk("R7", sdata, 1'b1, "first window cycle");
    mt = 0; idle(W - 2, "R7");
    mt = 1; step("R7");                      // last window cycle
    chk("R7", sdata, 1'b1, "last window cycle");
    step("R7");                              // just after window
    chk("R7", sdata, 1'b0, "after window, nav held");
    mt = 0; nav = 0; step("R7");

    // R8 retrigger
    nav = 1; step("R8"); nav = 0; idle(30, "R8");
    nav = 1; step("R8"); nav = 0; idle(W - 1, "R8");
    mt = 1; step("R8");
    chk("R8", sdata, 1'b1, "retriggered window still open");
    step("R8");
    chk("R8", sdata, 1'b0, "retriggered window closed");
    // R5 clear wins over match
    sen = 0; step("R5");
    chk("R5", irq_n, 1'b1, "sample cleared");
    chk("R5", sdata, 1'b0, "data cleared");
    mt = 0; idle(2, "R5");

    // R6 random mix
    for (int i = 0; i < 6000; i++) begin
      strb = ($urandom % 8 == 0) ? NS'($urandom) : '0;
      if ($urandom % 20 == 0) den = ~den;
      if ($urandom % 20 == 0) sen = ~sen;
      mt = ($urandom % 6 == 0);
      if ($urandom % 40 == 0) nav = ~nav;
      step("R6");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule